// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit carries one processor core from the moment an interrupt is raised to the moment the handler may start. Two sources can raise it. One is a device request, which is gated by a per-core enable flag. The other is a software interrupt instruction. Each source carries an interrupt number.

The unit forms the address of that number's entry in a vector table. The table's base comes from a per-core register. The unit then fetches two 32-bit words over a simple memory read port: first the handler's instruction pointer, then the handler's private stack pointer.

When both words are in, the unit pulses a load strobe for one cycle. The strobe hands three values to the core: the new instruction pointer, the new stack pointer, and a frame pointer. The frame pointer equals the stack pointer the core held when the interrupt was accepted. From acceptance until the strobe, the unit holds a stall to the pipeline.

A device request that cannot be served yet is remembered. A software interrupt wins over a device request in the same cycle.

Top module: `irqv_dispatch`

## Requirements
- R1: After reset, `stall`, `mem_rd_req` and `load_strobe` are low, no device request is pending, and the table base is 0x00000000.
- R2: The instruction-pointer word is read first, at base + ID×8. The stack-pointer word is read next, at base + ID×8 + 4. Exactly two reads are made per interrupt entry.
- R3: Once `mem_rd_req` is raised, it stays high with an unchanged `mem_rd_addr` until a cycle in which `mem_rd_valid` is high.
- R4: After the second word arrives, `load_strobe` is high for exactly one cycle. In that cycle `new_ip` and `new_sp` equal the first and second words returned. `stall` is high from the cycle after acceptance through the strobe cycle, and low in the cycle after the strobe.
- R5: `new_fp` at the strobe equals `cur_sp` as sampled in the acceptance cycle.
- R6: A software request is taken whenever the unit is idle. A device request is taken only while `hwint_en` is 1. While `hwint_en` is 0, no read is started for it.
- R7: When software and device requests coincide, the software entry is served first. The device entry follows right after.
- R8: A device request is latched until it is taken. Any further device request that arrives while one is pending is dropped, so only the first ID is served.
- R9: Writing `base_wr_data` with `base_wr_en` high sets the table base used by every later entry.
- R10: A software request that arrives while `stall` is high is ignored and starts no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Load the vector-table base |
| base_wr_data | input | ADDR_W | New vector-table base |
| hwint_en | input | 1 | Per-core device interrupt enable flag |
| hw_req | input | 1 | Device interrupt request pulse |
| hw_id | input | ID_W | Device interrupt number |
| sw_req | input | 1 | Software interrupt instruction request |
| sw_id | input | ID_W | Software interrupt number |
| cur_sp | input | DATA_W | Core's current stack pointer |
| mem_rd_req | output | 1 | Memory read request, held until served |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | DATA_W | Read data |
| stall | output | 1 | Pipeline stall while dispatching |
| load_strobe | output | 1 | One-cycle pointer load strobe |
| new_ip | output | DATA_W | Handler instruction pointer |
| new_sp | output | DATA_W | Handler stack pointer |
| new_fp | output | DATA_W | Frame pointer value for the core |

## Verification
The assertions assume that memory raises `mem_rd_valid` only while `mem_rd_req` is high, and that it answers each request within finite time. The bench's memory model keeps to this. It answers only requests it sees, after a chosen latency of 0 to 2 cycles, and returns a word computed from the address.

The assertions also assume that acceptance depends only on the request inputs and `hwint_en` in the acceptance cycle. The stimulus changes every input at the falling edge only, so each input value is steady across one rising edge.

The sweep covers every ID through both sources, under three table bases and all three latencies.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_IP = 2'd1,
    ST_FETCH_SP = 2'd2,
    ST_LOAD     = 2'd3
  } disp_state_t;

  localparam int ENTRY_SHIFT = 3;

endpackage

// File: rtl/irqv_req_arb.sv
module irqv_req_arb #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic            hwint_en,
  input  logic            hw_req,
  input  logic [ID_W-1:0] hw_id,
  input  logic            sw_req,
  input  logic [ID_W-1:0] sw_id,
  output logic            take,
  output logic [ID_W-1:0] take_id
);

  logic            pend_q;
  logic [ID_W-1:0] pend_id_q;
  logic            hw_take;

  // Software first; a pending device request waits for the enable flag.
  assign hw_take = idle && !sw_req && pend_q && hwint_en;
  assign take    = idle && (sw_req || (pend_q && hwint_en));
  assign take_id = sw_req ? sw_id : pend_id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_id_q <= '0;
    end else begin
      if (hw_take) begin
        pend_q <= 1'b0;
      end
      if (hw_req && (!pend_q || hw_take)) begin
        pend_q    <= 1'b1;
        pend_id_q <= hw_id;
      end
    end
  end

endmodule

// File: rtl/irqv_addr_gen.sv
module irqv_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic [ID_W-1:0]   id,
  output logic [ADDR_W-1:0] entry_addr
);

  localparam int PAD_W = ADDR_W - ID_W - irqv_pkg::ENTRY_SHIFT;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offset;

  assign offset     = {{PAD_W{1'b0}}, id, {irqv_pkg::ENTRY_SHIFT{1'b0}}};
  assign entry_addr = base_q + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (base_wr_en) begin
      base_q <= base_wr_data;
    end
  end

endmodule

// File: rtl/irqv_fetch_fsm.sv
module irqv_fetch_fsm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [DATA_W-1:0] cur_sp,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              idle,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              stall,
  output logic              load_strobe,
  output logic [DATA_W-1:0] new_ip,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_fp
);
  import irqv_pkg::*;

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);

  disp_state_t state_q;

  assign idle = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      stall       <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      load_strobe <= 1'b0;
      new_ip      <= '0;
      new_sp      <= '0;
      new_fp      <= '0;
    end else begin
      load_strobe <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q     <= ST_FETCH_IP;
            stall       <= 1'b1;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= entry_addr;
            new_fp      <= cur_sp;
          end
        end
        ST_FETCH_IP: begin
          if (mem_rd_valid) begin
            new_ip      <= mem_rd_data;
            mem_rd_addr <= mem_rd_addr + WORD_BYTES;
            state_q     <= ST_FETCH_SP;
          end
        end
        ST_FETCH_SP: begin
          if (mem_rd_valid) begin
            new_sp      <= mem_rd_data;
            mem_rd_req  <= 1'b0;
            load_strobe <= 1'b1;
            state_q     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          stall   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irqv_dispatch.sv
module irqv_dispatch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic              hwint_en,
  input  logic              hw_req,
  input  logic [ID_W-1:0]   hw_id,
  input  logic              sw_req,
  input  logic [ID_W-1:0]   sw_id,
  input  logic [DATA_W-1:0] cur_sp,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              stall,
  output logic              load_strobe,
  output logic [DATA_W-1:0] new_ip,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_fp
);

  logic              idle;
  logic              take;
  logic [ID_W-1:0]   take_id;
  logic [ADDR_W-1:0] entry_addr;

  irqv_req_arb #(.ID_W(ID_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .hwint_en (hwint_en),
    .hw_req   (hw_req),
    .hw_id    (hw_id),
    .sw_req   (sw_req),
    .sw_id    (sw_id),
    .take     (take),
    .take_id  (take_id)
  );

  irqv_addr_gen #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_addr (
    .clk          (clk),
    .rst          (rst),
    .base_wr_en   (base_wr_en),
    .base_wr_data (base_wr_data),
    .id           (take_id),
    .entry_addr   (entry_addr)
  );

  irqv_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .entry_addr   (entry_addr),
    .cur_sp       (cur_sp),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .idle         (idle),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .stall        (stall),
    .load_strobe  (load_strobe),
    .new_ip       (new_ip),
    .new_sp       (new_sp),
    .new_fp       (new_fp)
  );

endmodule

// File: rtl/irqv_dispatch_chk.sv
module irqv_dispatch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_req,
  input logic              hwint_en,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              stall,
  input logic              load_strobe,
  input logic [DATA_W-1:0] new_fp
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_second_word_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_rd_req && mem_rd_valid) && mem_rd_req)
      |-> (mem_rd_addr == $past(mem_rd_addr) + WORD_BYTES));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> !load_strobe);

  assert_strobe_in_stall_R4: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> (stall && !mem_rd_req));

  assert_stall_ends_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> $past(load_strobe));

  assert_accept_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> ($past(sw_req) || $past(hwint_en)));

  assert_fp_held_R5: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> $stable(new_fp));

endmodule

bind irqv_dispatch irqv_dispatch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sw_req       (sw_req),
  .hwint_en     (hwint_en),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .stall        (stall),
  .load_strobe  (load_strobe),
  .new_fp       (new_fp)
);

// File: tb/irqv_dispatch_tb.sv
module irqv_dispatch_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        hwint_en = 1'b0;
  logic        hw_req = 1'b0;
  logic [4:0]  hw_id = '0;
  logic        sw_req = 1'b0;
  logic [4:0]  sw_id = '0;
  logic [31:0] cur_sp = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        stall, load_strobe;
  logic [31:0] new_ip, new_sp, new_fp;

  int vectors = 0;
  int fails   = 0;
  int lat     = 0;
  int wait_cnt = 0;
  int log_n   = 0;
  logic [31:0] rd_log [0:2047];
  logic [31:0] cur_base = 32'h0;

  always #10 clk = ~clk;

  irqv_dispatch u_dut (
    .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .hwint_en(hwint_en), .hw_req(hw_req), .hw_id(hw_id), .sw_req(sw_req),
    .sw_id(sw_id), .cur_sp(cur_sp), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .stall(stall), .load_strobe(load_strobe),
    .new_ip(new_ip), .new_sp(new_sp), .new_fp(new_fp)
  );

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC001D00D;
  endfunction

  // Memory model: answers a held request after lat cycles.
  always @(negedge clk) begin
    if (mem_rd_req) begin
      if (wait_cnt >= lat) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = memw(mem_rd_addr);
        if (log_n < 2048) rd_log[log_n] = mem_rd_addr;
        log_n++;
        wait_cnt = 0;
      end else begin
        mem_rd_valid = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_rd_valid = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    cur_base = b;
  endtask

  // Wait for the strobe and check one whole entry.
  task automatic wait_entry(input int start, input logic [4:0] id,
                            input logic [31:0] exp_fp);
    logic [31:0] a0;
    bit seen = 0;
    a0 = cur_base + {24'd0, id, 3'b000};
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (load_strobe) begin
        seen = 1;
        break;
      end
    end
    chk("R4 strobe seen", 32'(seen), 32'd1);
    chk("R2 read count", 32'(log_n - start), 32'd2);
    chk("R2 ip address", rd_log[start], a0);
    chk("R2 sp address", rd_log[start + 1], a0 + 32'd4);
    chk("R4 new_ip", new_ip, memw(a0));
    chk("R4 new_sp", new_sp, memw(a0 + 32'd4));
    chk("R5 new_fp", new_fp, exp_fp);
    chk("R4 stall at strobe", 32'(stall), 32'd1);
    @(negedge clk);
    chk("R4 strobe one cycle", 32'(load_strobe), 32'd0);
    chk("R4 stall released", 32'(stall), 32'd0);
  endtask

  task automatic sw_entry(input logic [4:0] id, input logic [31:0] sp);
    int start;
    @(negedge clk);
    start = log_n;
    cur_sp = sp;
    sw_req = 1'b1;
    sw_id  = id;
    @(negedge clk);
    sw_req = 1'b0;
    cur_sp = ~sp;
    wait_entry(start, id, sp);
  endtask

  task automatic hw_entry(input logic [4:0] id, input logic [31:0] sp);
    int start;
    @(negedge clk);
    start = log_n;
    hwint_en = 1'b1;
    cur_sp = sp;
    hw_req = 1'b1;
    hw_id  = id;
    @(negedge clk);
    hw_req = 1'b0;
    @(negedge clk);
    cur_sp = ~sp;
    wait_entry(start, id, sp);
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, 32'(mem_rd_req), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] bases [3];
    int start;
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h0004_0100;
    bases[2] = 32'h8000_1F00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 stall", 32'(stall), 32'd0);
    chk("R1 mem_rd_req", 32'(mem_rd_req), 32'd0);
    chk("R1 load_strobe", 32'(load_strobe), 32'd0);
    quiet(3, "R1 no pending request");

    // R1 base at zero, R9 base writes, R2/R4/R5/R6 sweep
    for (int b = 0; b < 3; b++) begin
      if (b != 0) set_base(bases[b]);
      for (int id = 0; id < 32; id++) begin
        lat = id % 3;
        sw_entry(5'(id), 32'h1000_0000 + 32'(id * 16 + b));
        lat = (id + 1) % 3;
        hw_entry(5'(id), 32'h2000_0000 + 32'(id * 16 + b));
      end
    end

    // R6 / R8: disabled device request stays pending, second one dropped
    lat = 1;
    @(negedge clk);
    hwint_en = 1'b0;
    hw_req = 1'b1;
    hw_id = 5'd7;
    @(negedge clk);
    hw_req = 1'b0;
    quiet(4, "R6 no read while disabled");
    @(negedge clk);
    hw_req = 1'b1;
    hw_id = 5'd9;
    @(negedge clk);
    hw_req = 1'b0;
    quiet(4, "R6 no read while disabled");
    @(negedge clk);
    start = log_n;
    cur_sp = 32'h0BAD_F00D;
    hwint_en = 1'b1;
    wait_entry(start, 5'd7, 32'h0BAD_F00D);
    quiet(6, "R8 second request dropped");

    // R7: coincident requests, software first
    @(negedge clk);
    start = log_n;
    cur_sp = 32'h3333_0000;
    sw_req = 1'b1;
    sw_id = 5'd20;
    hw_req = 1'b1;
    hw_id = 5'd3;
    @(negedge clk);
    sw_req = 1'b0;
    hw_req = 1'b0;
    wait_entry(start, 5'd20, 32'h3333_0000);
    start = log_n;
    cur_sp = 32'h4444_0000;
    wait_entry(start, 5'd3, 32'h4444_0000);
    chk("R7 software then device order", rd_log[start - 2], cur_base + 32'd160);

    // R10: software request during a busy entry is ignored
    lat = 2;
    @(negedge clk);
    start = log_n;
    cur_sp = 32'h5555_0000;
    sw_req = 1'b1;
    sw_id = 5'd4;
    @(negedge clk);
    sw_req = 1'b0;
    @(negedge clk);
    sw_req = 1'b1;
    sw_id = 5'd11;
    @(negedge clk);
    sw_req = 1'b0;
    wait_entry(start, 5'd4, 32'h5555_0000);
    quiet(6, "R10 busy request ignored");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule